// File: doc/BRIEF.md
# Pulsed Radar Timing Sequencer

The block produces the repeating timing of a pulsed radar. Each pulse period is made of four phases in fixed order: transmit on, transmit-to-receive switchover, receive look window and inter-pulse idle. Each phase has its own programmable 24-bit length, loaded as the desired cycle count minus one. After the last idle cycle the next period starts with the on phase.

Configuration arrives over a plain address/data/write-strobe port. A mode register holds a hold bit, which keeps the sequencer parked while it is configured. Clearing the bit starts pulse generation. New lengths written during operation are staged and are applied only at the start of the next period.

The outputs are a transmit enable, a receive enable and a one-cycle pulse-start strobe. There are also two antenna-switch controls. Each control copies its enable, shifted later by its own programmable delay.

Top module: `radar_pulse_seq`

## Requirements
- R1: After the asynchronous active-low reset, all outputs are low, every length and delay register is zero, and the hold bit is set, so the sequencer stays inactive.
- R2: A write takes place on a rising edge where `cfg_we_i` is high. The register map is:
  - address 0: hold bit in data bit 0.
  - address 1: on length.
  - address 2: switchover length.
  - address 3: look length.
  - address 4: idle length.
  - address 5: delays, with the transmit delay in bits 31:16 and the receive delay in bits 15:0.
  - Each length sits in data bits 23:0.
- R3: While running, phases follow the order on, switchover, look, idle and then repeat. Each phase lasts its programmed value plus one cycles.
- R4: While the hold bit is set, all outputs are low from the second rising edge after the write that set it. When a write clears the bit, `tx_en_o` goes high after the second rising edge following that write.
- R5: `tx_en_o` is high exactly during the on phase and `rx_en_o` exactly during the look phase; the two are never high together.
- R6: `pulse_start_o` is high for exactly the first cycle of every on phase.
- R7: A length written while running does not affect the current period. The value held in the staging register at the last idle cycle's closing edge is used from the next period on.
- R8: A length value of zero gives a phase of exactly one cycle.
- R9: Each switch control equals its enable as it was D cycles earlier, where D is the programmed delay; a delay of 0 passes the enable in the same cycle.
- R10: Delays are captured when the sequencer leaves hold, and the switch controls are low while it is inactive. Correct delayed output is assured for delays shorter than the pulse period.
- R11: Writes to addresses 6 and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_addr_i | input | 7 | Configuration register address |
| cfg_data_i | input | 32 | Configuration write data |
| cfg_we_i | input | 1 | Write strobe, one cycle per write |
| tx_en_o | output | 1 | High during the on phase |
| rx_en_o | output | 1 | High during the look phase |
| pulse_start_o | output | 1 | One-cycle strobe on the first on cycle |
| tx_sw_o | output | 1 | Delayed transmit antenna-switch control |
| rx_sw_o | output | 1 | Delayed receive antenna-switch control |

## Verification
- A wrong phase or count value shows at the enables within one phase length. The wrong value moves an edge of `tx_en_o` or `rx_en_o` or a `pulse_start_o` strobe, and every cycle is compared against a behavioural model.
- A wrong active copy of a length, or a reload at the wrong moment, shows in the following period as a shifted edge.
- A wrong delay counter shows on the switch control within the programmed delay after the next enable edge.
- A hold or decode fault shows as enables that start, or fail to start, two edges after the offending write.

// File: rtl/radar_seq_pkg.sv
package radar_seq_pkg;
  localparam int NUM_PH = 4;
  localparam int NUM_SW = 2;

  typedef enum logic [1:0] {
    PH_ON   = 2'd0,
    PH_SW   = 2'd1,
    PH_LOOK = 2'd2,
    PH_IDLE = 2'd3
  } phase_e;

  localparam int ADDR_MODE     = 0;
  localparam int ADDR_LEN_BASE = 1;  // on, switch, look, idle follow in phase order
  localparam int ADDR_DLY      = 5;
endpackage

// File: rtl/radar_cfg_regs.sv
module radar_cfg_regs
  import radar_seq_pkg::*;
#(
  parameter int AW    = 7,
  parameter int DW    = 32,
  parameter int LEN_W = 24,
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic             we_i,
  output logic             hold_o,
  output logic [LEN_W-1:0] len_o [NUM_PH],
  output logic [DLY_W-1:0] dly_o [NUM_SW]
);
  localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);
  localparam logic [AW-1:0] A_DLY  = AW'(ADDR_DLY);
  localparam int            HI_LSB = DW / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b1;
      for (int p = 0; p < NUM_PH; p++) len_o[p] <= '0;
      for (int s = 0; s < NUM_SW; s++) dly_o[s] <= '0;
    end else if (we_i) begin
      if (addr_i == A_MODE) hold_o <= data_i[0];
      for (int p = 0; p < NUM_PH; p++)
        if (addr_i == AW'(ADDR_LEN_BASE + p)) len_o[p] <= data_i[LEN_W-1:0];
      if (addr_i == A_DLY) begin
        dly_o[0] <= data_i[HI_LSB +: DLY_W];
        dly_o[1] <= data_i[0 +: DLY_W];
      end
    end
  end
endmodule

// File: rtl/radar_phase_ctrl.sv
module radar_phase_ctrl
  import radar_seq_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [LEN_W-1:0] len_i [NUM_PH],
  output logic             run_o,
  output phase_e           phase_o,
  output logic             first_o
);
  logic [LEN_W-1:0] act_q [NUM_PH];
  logic [LEN_W-1:0] cnt_q;
  logic             last;

  assign last    = (cnt_q == act_q[phase_o]);
  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      phase_o <= PH_ON;
      cnt_q   <= '0;
      for (int p = 0; p < NUM_PH; p++) act_q[p] <= '0;
    end else if (hold_i) begin
      run_o   <= 1'b0;
      phase_o <= PH_ON;
      cnt_q   <= '0;
    end else if (!run_o) begin
      run_o   <= 1'b1;
      phase_o <= PH_ON;
      cnt_q   <= '0;
      act_q   <= len_i;
    end else if (last) begin
      cnt_q   <= '0;
      phase_o <= phase_e'(phase_o + 2'd1);
      if (phase_o == PH_IDLE) act_q <= len_i;  // staged lengths apply per period
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/radar_sw_delay.sv
module radar_sw_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             en_i,
  output logic             sw_o
);
  logic [DLY_W-1:0] dly_q, rcnt_q, fcnt_q;
  logic             rpend_q, fpend_q, en_q, sw_q;
  logic             rise, fall;

  assign rise = en_i & ~en_q;
  assign fall = ~en_i & en_q;
  assign sw_o = ~clr_i & ((dly_q == '0) ? en_i : sw_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= '0;
      rcnt_q  <= '0;
      fcnt_q  <= '0;
      rpend_q <= 1'b0;
      fpend_q <= 1'b0;
      en_q    <= 1'b0;
      sw_q    <= 1'b0;
    end else if (clr_i) begin
      dly_q   <= dly_i;
      rpend_q <= 1'b0;
      fpend_q <= 1'b0;
      en_q    <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      // one pending edge per direction; delay shorter than the period
      if (rise) begin
        if (dly_q == DLY_W'(1)) sw_q <= 1'b1;
        else if (dly_q > DLY_W'(1)) begin
          rpend_q <= 1'b1;
          rcnt_q  <= dly_q - DLY_W'(1);
        end
      end else if (rpend_q) begin
        if (rcnt_q == DLY_W'(1)) begin
          sw_q    <= 1'b1;
          rpend_q <= 1'b0;
        end else rcnt_q <= rcnt_q - DLY_W'(1);
      end
      if (fall) begin
        if (dly_q == DLY_W'(1)) sw_q <= 1'b0;
        else if (dly_q > DLY_W'(1)) begin
          fpend_q <= 1'b1;
          fcnt_q  <= dly_q - DLY_W'(1);
        end
      end else if (fpend_q) begin
        if (fcnt_q == DLY_W'(1)) begin
          sw_q    <= 1'b0;
          fpend_q <= 1'b0;
        end else fcnt_q <= fcnt_q - DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/radar_pulse_seq.sv
module radar_pulse_seq
  import radar_seq_pkg::*;
#(
  parameter int AW    = 7,
  parameter int DW    = 32,
  parameter int LEN_W = 24,
  parameter int DLY_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_data_i,
  input  logic          cfg_we_i,
  output logic          tx_en_o,
  output logic          rx_en_o,
  output logic          pulse_start_o,
  output logic          tx_sw_o,
  output logic          rx_sw_o
);
  logic             hold;
  logic [LEN_W-1:0] len   [NUM_PH];
  logic [DLY_W-1:0] dly   [NUM_SW];
  logic             seq_run, seq_first;
  phase_e           seq_phase;
  logic [NUM_SW-1:0] sw_en, sw_out;

  radar_cfg_regs #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .DLY_W(DLY_W)) u_regs (
    .clk_i, .rst_ni, .addr_i(cfg_addr_i), .data_i(cfg_data_i), .we_i(cfg_we_i),
    .hold_o(hold), .len_o(len), .dly_o(dly)
  );

  radar_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .hold_i(hold), .len_i(len),
    .run_o(seq_run), .phase_o(seq_phase), .first_o(seq_first)
  );

  assign tx_en_o       = seq_run & (seq_phase == PH_ON);
  assign rx_en_o       = seq_run & (seq_phase == PH_LOOK);
  assign pulse_start_o = tx_en_o & seq_first;

  assign sw_en = {rx_en_o, tx_en_o};

  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    radar_sw_delay #(.DLY_W(DLY_W)) u_dly (
      .clk_i, .rst_ni, .clr_i(~seq_run), .dly_i(dly[s]),
      .en_i(sw_en[s]), .sw_o(sw_out[s])
    );
  end

  assign tx_sw_o = sw_out[0];
  assign rx_sw_o = sw_out[1];
endmodule

// File: rtl/radar_pulse_seq_chk.sv
module radar_pulse_seq_chk #(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] cfg_addr_i,
  input logic          cfg_hold_bit_i,
  input logic          cfg_we_i,
  input logic          tx_en_o,
  input logic          rx_en_o,
  input logic          pulse_start_o,
  input logic          tx_sw_o,
  input logic          rx_sw_o,
  input logic          run_i,
  input logic [1:0]    phase_i
);
  assert_excl_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_o && rx_en_o));

  assert_start_in_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_start_o |-> tx_en_o);

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_start_o |=> !pulse_start_o);

  assert_phase_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && phase_i != $past(phase_i)) |-> (phase_i == $past(phase_i) + 2'd1));

  assert_hold_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == '0 && cfg_hold_bit_i) |=> ##1 (!tx_en_o && !rx_en_o && !pulse_start_o));

  assert_sw_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!tx_sw_o && !rx_sw_o));
endmodule

bind radar_pulse_seq radar_pulse_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_addr_i(cfg_addr_i),
  .cfg_hold_bit_i(cfg_data_i[0]), .cfg_we_i(cfg_we_i),
  .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .pulse_start_o(pulse_start_o),
  .tx_sw_o(tx_sw_o), .rx_sw_o(rx_sw_o),
  .run_i(seq_run), .phase_i(seq_phase)
);

// File: tb/radar_pulse_seq_test.sv
`timescale 1ns/1ps
module radar_pulse_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] data = '0;
  logic        we = 1'b0;
  logic        tx_en, rx_en, pstart, tx_sw, rx_sw;

  int checks = 0;
  int errors = 0;
  string scen = "R1";

  radar_pulse_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(addr), .cfg_data_i(data), .cfg_we_i(we),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .pulse_start_o(pstart),
    .tx_sw_o(tx_sw), .rx_sw_o(rx_sw)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  bit m_hold = 1'b1;
  bit m_run  = 1'b0;
  int m_ph   = 0;
  int m_cnt  = 0;
  int m_stage [4] = '{0, 0, 0, 0};
  int m_act   [4] = '{0, 0, 0, 0};
  int m_dst   [2] = '{0, 0};
  int m_dly   [2] = '{0, 0};
  bit q_tx[$];
  bit q_rx[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 1'b1; m_run = 1'b0; m_ph = 0; m_cnt = 0;
      m_stage = '{0, 0, 0, 0}; m_act = '{0, 0, 0, 0};
      m_dst = '{0, 0}; m_dly = '{0, 0};
    end else begin
      if (m_hold) begin
        m_run = 1'b0; m_ph = 0; m_cnt = 0;
      end else if (!m_run) begin
        m_run = 1'b1; m_ph = 0; m_cnt = 0; m_act = m_stage; m_dly = m_dst;
      end else if (m_cnt == m_act[m_ph]) begin
        m_cnt = 0;
        if (m_ph == 3) m_act = m_stage;
        m_ph = (m_ph + 1) % 4;
      end else m_cnt++;
      if (we) begin
        if (addr == 7'd0) m_hold = data[0];
        else if (addr >= 7'd1 && addr <= 7'd4) m_stage[addr - 1] = int'(data[23:0]);
        else if (addr == 7'd5) begin
          m_dst[0] = int'(data[31:16]);
          m_dst[1] = int'(data[15:0]);
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, what, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_tx, e_rx, e_st, e_txs, e_rxs;
    e_tx = m_run && m_ph == 0;
    e_rx = m_run && m_ph == 2;
    e_st = e_tx && m_cnt == 0;
    if (m_run) begin
      q_tx.push_back(e_tx); q_rx.push_back(e_rx);
      if (q_tx.size() > 70000) begin void'(q_tx.pop_front()); void'(q_rx.pop_front()); end
    end else begin
      q_tx.delete(); q_rx.delete();
    end
    e_txs = m_run && ((m_dly[0] == 0) ? e_tx : (q_tx.size() > m_dly[0] ? q_tx[q_tx.size() - 1 - m_dly[0]] : 1'b0));
    e_rxs = m_run && ((m_dly[1] == 0) ? e_rx : (q_rx.size() > m_dly[1] ? q_rx[q_rx.size() - 1 - m_dly[1]] : 1'b0));
    chk({"R3/R5 ", scen}, "tx_en", tx_en, e_tx);
    chk({"R3/R5 ", scen}, "rx_en", rx_en, e_rx);
    chk({"R6 ", scen}, "pulse_start", pstart, e_st);
    chk({"R9/R10 ", scen}, "tx_sw", tx_sw, e_txs);
    chk({"R9/R10 ", scen}, "rx_sw", rx_sw, e_rxs);
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; data = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(3);
    #(CLK_PERIOD / 4) rst_n = 1'b1;
    cycles(4);
    scen = "R1";
    chk("R1", "tx_en after reset", tx_en, 1'b0);
    chk("R1", "tx_sw after reset", tx_sw, 1'b0);

    // addresses past the map must not alias onto the mode register
    scen = "R11";
    wr(7'd6, 32'h0);
    wr(7'd7, 32'h0);
    wr(7'd64, 32'h0);
    cycles(4);
    chk("R11", "tx_en stays held", tx_en, 1'b0);

    // small period with delays
    scen = "R2";
    wr(7'd1, 32'd3);
    wr(7'd2, 32'd1);
    wr(7'd3, 32'd4);
    wr(7'd4, 32'd2);
    wr(7'd5, {16'd2, 16'd3});
    scen = "R4";
    wr(7'd0, 32'd0);
    chk("R4", "tx_en one edge after release", tx_en, 1'b0);
    cycles(1);
    chk("R4", "tx_en two edges after release", tx_en, 1'b1);
    chk("R6", "pulse_start on first on cycle", pstart, 1'b1);
    scen = "R3";
    cycles(40);

    // zero lengths written during operation
    scen = "R7";
    wr(7'd1, 32'd0);
    cycles(3);
    wr(7'd3, 32'd0);
    scen = "R8";
    cycles(40);

    // hold again, zero delays, minimum period
    scen = "R4";
    wr(7'd0, 32'd1);
    cycles(1);
    chk("R4", "tx_en low under hold", tx_en, 1'b0);
    chk("R10", "rx_sw low under hold", rx_sw, 1'b0);
    scen = "R9";
    wr(7'd5, 32'd0);
    wr(7'd2, 32'd0);
    wr(7'd4, 32'd0);
    wr(7'd0, 32'd0);
    cycles(30);

    // delay written while running must wait for the next release
    scen = "R10";
    wr(7'd5, {16'd1, 16'd2});
    cycles(20);
    wr(7'd0, 32'd1);
    wr(7'd0, 32'd0);
    cycles(30);

    // realistic period with long delays
    scen = "R3";
    wr(7'd0, 32'd1);
    wr(7'd1, 32'd319);
    wr(7'd2, 32'd25);
    wr(7'd3, 32'd639);
    wr(7'd4, 32'd2853);
    wr(7'd5, {16'd64, 16'd70});
    wr(7'd0, 32'd0);
    cycles(8000);

    finish_run();
  end
endmodule